// File: doc/BRIEF.md
# Address Range Protection Checker

This block guards a single window of memory against stray accesses from a transfer engine. Software programs a lower and an upper bound through a small single-cycle register port, then turns checking on. From then on, every address the engine presents with its valid strobe is compared against the window. An address outside the window sets a sticky error flag on the next clock edge. The address of the first offending access is kept so that software can read it.

Both bounds are word aligned, and the upper bound covers the whole of its last word. Every register write counts only when the bus cycle is privileged. Reads are open to any mode. Software clears the error by writing 1 to the status flag bit. A violation in the same cycle as the clear keeps the flag set.

Register offsets: 0x74 lower bound, 0x78 upper bound, 0x7C control (bit 0 = check enable), 0x80 status (bit 0 = error flag, write 1 to clear), 0x84 captured address (read-only). Unmapped offsets read 0.

Top module: `range_guard`

## Requirements
- R1: After reset, both bounds, the control register, the status register and the captured address read 0, and `protErr` is low.
- R2: Bits 1:0 of the lower-bound (0x74) and upper-bound (0x78) registers are not stored and always read as 0.
- R3: A write with `busPriv` low changes no register. This covers the bounds, the control register and the error clear. Reads return data whatever `busPriv` is.
- R4: With checking enabled, a strobed address below the lower bound sets `protErr`.
- R5: With checking enabled, a strobed address above the effective upper bound sets `protErr`.
- R6: The effective upper bound is the programmed value with bits 1:0 forced to 11. With the upper bound at 0x200, address 0x203 is inside and 0x204 is outside.
- R7: An address equal to the lower bound is inside the window and raises no error.
- R8: While control bit 0 is 0, no address raises an error.
- R9: `protErr` rises on the clock edge that samples the violating strobe. It then stays high until a privileged write of 1 to status bit 0. If a violation arrives in the same cycle as that clear, the flag stays set.
- R10: The captured-address register (0x84) takes the address of the first violation while the flag is clear. Later violations do not overwrite it until the flag has been cleared.
- R11: When `chkValid` is low, `chkAddr` is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register port access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busPriv | input | 1 | Access is privileged |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, 0 when not reading) |
| chkValid | input | 1 | Checked address is valid |
| chkAddr | input | 32 | Address issued by the transfer engine |
| protErr | output | 1 | Sticky protection error flag |

## Verification
The bench probes the window edges where off-by-one mistakes hide. These are the exact lower bound, the last byte of the rounded upper word and the first byte past it. A strict comparison at the lower bound, or a missing round-up at the top, would flag legal accesses. A comparison that is too loose would miss the byte just past the end. It issues unprivileged writes to every writable register, including the error clear. A design that ignored privilege would change a bound or drop the flag. It also lands a violation on the same cycle as a clear, and a second violation after the first. A design with the wrong priority, or one that recaptures on every violation, would lose the flag or overwrite the recorded address.

// File: rtl/range_guard_pkg.sv
package range_guard_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_START,
    RD_END,
    RD_CTRL,
    RD_STATUS,
    RD_CAPTURE
  } rdSel_e;

  typedef struct packed {
    logic   wrStart;
    logic   wrEnd;
    logic   wrCtrl;
    logic   clrErr;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/range_guard_ctrl.sv
module range_guard_ctrl
  import range_guard_pkg::*;
#(
  parameter int OFFS_W      = 8,
  parameter int DATA_W      = 32,
  parameter int OFF_START   = 'h74,
  parameter int OFF_END     = 'h78,
  parameter int OFF_CTRL    = 'h7C,
  parameter int OFF_STATUS  = 'h80,
  parameter int OFF_CAPTURE = 'h84,
  parameter int ERR_BIT     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busPriv,
  input  logic [OFFS_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output regStrobe_t        strobe
);

  logic hitStart, hitEnd, hitCtrl, hitStatus, hitCapture;
  logic wrOk, rdOk;

  assign hitStart   = busAddr == OFFS_W'(OFF_START);
  assign hitEnd     = busAddr == OFFS_W'(OFF_END);
  assign hitCtrl    = busAddr == OFFS_W'(OFF_CTRL);
  assign hitStatus  = busAddr == OFFS_W'(OFF_STATUS);
  assign hitCapture = busAddr == OFFS_W'(OFF_CAPTURE);

  // Privilege gates every write; reads are open to all modes.
  assign wrOk = busSel && busWr && busPriv;
  assign rdOk = busSel && !busWr;

  always_comb begin
    strobe.wrStart = wrOk && hitStart;
    strobe.wrEnd   = wrOk && hitEnd;
    strobe.wrCtrl  = wrOk && hitCtrl;
    strobe.clrErr  = wrOk && hitStatus && busWdata[ERR_BIT];
    strobe.rdSel   = RD_NONE;
    if (rdOk) begin
      if (hitStart)        strobe.rdSel = RD_START;
      else if (hitEnd)     strobe.rdSel = RD_END;
      else if (hitCtrl)    strobe.rdSel = RD_CTRL;
      else if (hitStatus)  strobe.rdSel = RD_STATUS;
      else if (hitCapture) strobe.rdSel = RD_CAPTURE;
    end
  end

  // R3: an unprivileged write must produce no write strobe at all
  p_unpriv_no_strobe_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busPriv) |->
      !(strobe.wrStart || strobe.wrEnd || strobe.wrCtrl || strobe.clrErr));

  // R3: read selection only during reads
  p_rdsel_only_on_read_r3 : assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |-> strobe.rdSel == RD_NONE);

endmodule

// File: rtl/range_guard_dp.sv
module range_guard_dp
  import range_guard_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2,
  parameter int EN_BIT  = 0,
  parameter int ERR_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              chkValid,
  input  logic [DATA_W-1:0] chkAddr,
  output logic              protErr
);

  localparam int HI_W = DATA_W - ALIGN_W;

  logic [HI_W-1:0]   startHi, endHi;
  logic              enReg, errReg;
  logic [DATA_W-1:0] capReg;
  logic [DATA_W-1:0] startFull, endEff;
  logic              belowStart, aboveEnd, violate;

  assign startFull = {startHi, {ALIGN_W{1'b0}}};
  assign endEff    = {endHi, {ALIGN_W{1'b1}}};   // whole last word inside

  assign belowStart = chkAddr < startFull;
  assign aboveEnd   = chkAddr > endEff;
  assign violate    = chkValid && enReg && (belowStart || aboveEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startHi <= '0;
      endHi   <= '0;
      enReg   <= 1'b0;
    end else begin
      if (strobe.wrStart) startHi <= busWdata[DATA_W-1:ALIGN_W];
      if (strobe.wrEnd)   endHi   <= busWdata[DATA_W-1:ALIGN_W];
      if (strobe.wrCtrl)  enReg   <= busWdata[EN_BIT];
    end
  end

  // Sticky flag: a new violation wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg <= 1'b0;
      capReg <= '0;
    end else begin
      if (violate)            errReg <= 1'b1;
      else if (strobe.clrErr) errReg <= 1'b0;
      if (violate && !errReg) capReg <= chkAddr;
    end
  end

  assign protErr = errReg;

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdSel)
      RD_START:   busRdata = startFull;
      RD_END:     busRdata = {endHi, {ALIGN_W{1'b0}}};
      RD_CTRL:    busRdata[EN_BIT] = enReg;
      RD_STATUS:  busRdata[ERR_BIT] = errReg;
      RD_CAPTURE: busRdata = capReg;
      default:    busRdata = '0;
    endcase
  end

  // R9: the flag holds until a clear strobe
  p_err_sticky_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (protErr && !strobe.clrErr) |=> protErr);

  // R8 / R11: with no qualifying strobe a clear flag stays clear
  p_no_spurious_err_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (!protErr && (!chkValid || !enReg)) |=> !protErr);

  // R4 / R5: an out-of-window strobe with checking on sets the flag next edge
  p_outside_sets_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && enReg && (chkAddr < startFull || chkAddr > endEff)) |=> protErr);

  // R10: captured address frozen while the flag is up
  p_capture_frozen_r10 : assert property (@(posedge clk) disable iff (!rstN)
    protErr |=> $stable(capReg));

  // R2: bound read-back never carries the alignment bits
  p_bound_align_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_START || strobe.rdSel == RD_END) |-> busRdata[ALIGN_W-1:0] == '0);

endmodule

// File: rtl/range_guard.sv
module range_guard
  import range_guard_pkg::*;
#(
  parameter int OFFS_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busPriv,
  input  logic [OFFS_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              chkValid,
  input  logic [DATA_W-1:0] chkAddr,
  output logic              protErr
);

  regStrobe_t strobe;

  range_guard_ctrl #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busPriv(busPriv),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe)
  );

  range_guard_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .chkValid(chkValid), .chkAddr(chkAddr), .protErr(protErr)
  );

endmodule

// File: tb/range_guard_bench.sv
module range_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, busPriv = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        chkValid = 1'b0;
  logic [31:0] chkAddr = '0;
  logic        protErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [7:0] A_START = 8'h74, A_END = 8'h78, A_CTRL = 8'h7C,
                         A_STAT = 8'h80, A_CAP = 8'h84;

  always #10 clk = ~clk;   // 50 MHz

  range_guard u_range_guard (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busPriv(busPriv),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .chkValid(chkValid), .chkAddr(chkAddr), .protErr(protErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic priv);
    @(negedge clk);
    busSel = 1; busWr = 1; busPriv = priv; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busPriv = 0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic priv, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busPriv = priv; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0; busPriv = 0;
  endtask

  task automatic probe(input logic [31:0] addr, input logic valid);
    @(negedge clk);
    chkValid = valid; chkAddr = addr;
    @(negedge clk);
    chkValid = 0; chkAddr = '0;
  endtask

  task automatic clearErr();
    busWrite(A_STAT, 32'h1, 1'b1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 protErr", {31'b0, protErr}, 0);
    busRead(A_START, 0, d); check("R1 start", d, 0);
    busRead(A_END, 0, d);   check("R1 end", d, 0);
    busRead(A_CTRL, 0, d);  check("R1 ctrl", d, 0);
    busRead(A_STAT, 0, d);  check("R1 status", d, 0);
    busRead(A_CAP, 0, d);   check("R1 capture", d, 0);
  endtask

  task automatic testAlignAndPriv();
    logic [31:0] d;
    busWrite(A_START, 32'h0000_0107, 1);
    busRead(A_START, 0, d); check("R2 start low bits", d, 32'h104);
    busWrite(A_END, 32'h0000_0203, 1);
    busRead(A_END, 1, d);   check("R2 end low bits", d, 32'h200);
    busWrite(A_END, 32'h0000_0FF0, 0);
    busRead(A_END, 0, d);   check("R3 unpriv end write ignored", d, 32'h200);
    busWrite(A_START, 32'h0, 0);
    busRead(A_START, 0, d); check("R3 unpriv start write ignored", d, 32'h104);
    busWrite(A_CTRL, 32'h1, 0);
    busRead(A_CTRL, 0, d);  check("R3 unpriv ctrl write ignored", d, 0);
    busWrite(A_START, 32'h100, 1);
    busWrite(A_CTRL, 32'h1, 1);
    busRead(A_CTRL, 0, d);  check("R3 priv ctrl write", d, 1);
  endtask

  task automatic testBounds();
    logic [31:0] d;
    probe(32'h100, 1); check("R7 start exact inside", {31'b0, protErr}, 0);
    probe(32'h203, 1); check("R6 last byte of end word inside", {31'b0, protErr}, 0);
    probe(32'h0FC, 1); check("R4 below start", {31'b0, protErr}, 1);
    busRead(A_CAP, 0, d); check("R10 capture first", d, 32'h0FC);
    probe(32'h300, 1); check("R9 still set", {31'b0, protErr}, 1);
    busRead(A_CAP, 0, d); check("R10 capture not overwritten", d, 32'h0FC);
    busWrite(A_STAT, 32'h1, 0);
    check("R3 unpriv clear ignored", {31'b0, protErr}, 1);
    clearErr();
    check("R9 cleared by W1C", {31'b0, protErr}, 0);
    probe(32'h204, 1); check("R6 first byte past end", {31'b0, protErr}, 1);
    busRead(A_CAP, 0, d); check("R10 recapture after clear", d, 32'h204);
    clearErr();
    probe(32'hFFFF_FFFC, 1); check("R5 far above end", {31'b0, protErr}, 1);
    clearErr();
  endtask

  task automatic testTimingAndPriority();
    // flag must not be visible before the sampling edge
    @(negedge clk);
    chkValid = 1; chkAddr = 32'h10;
    #1 check("R9 no combinational flag", {31'b0, protErr}, 0);
    @(negedge clk);
    chkValid = 0;
    check("R9 set after edge", {31'b0, protErr}, 1);
    // violation and clear in the same cycle
    @(negedge clk);
    chkValid = 1; chkAddr = 32'h20;
    busSel = 1; busWr = 1; busPriv = 1; busAddr = A_STAT; busWdata = 32'h1;
    @(negedge clk);
    chkValid = 0; busSel = 0; busWr = 0; busPriv = 0; busWdata = '0;
    check("R9 set beats clear", {31'b0, protErr}, 1);
    clearErr();
  endtask

  task automatic testDisableAndValid();
    probe(32'h0, 0); check("R11 invalid strobe ignored", {31'b0, protErr}, 0);
    busWrite(A_CTRL, 32'h0, 1);
    probe(32'h0, 1); check("R8 disabled no error", {31'b0, protErr}, 0);
    probe(32'hFFFF_FFF0, 1); check("R8 disabled high address", {31'b0, protErr}, 0);
  endtask

  initial begin
    #35 check("R1 protErr in reset", {31'b0, protErr}, 0);
    rstN = 1;
    testReset();
    testAlignAndPriv();
    testBounds();
    testTimingAndPriority();
    testDisableAndValid();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule